// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps wall-clock time and a calendar for a chip that runs on a 32.768 kHz time base. A prescaler turns the slow clock enable into one increment per second. That increment ripples through packed-BCD seconds, minutes, hours, date, month and year counters, and through a binary day-of-week counter. Date rollover follows the length of each month. February gets its 29th day in years divisible by four.

Software reaches the counters through a small address/data register port. To load a new time, software raises a set request and polls until the block acknowledges it. The acknowledge appears at the next half-second point of the prescaler, and counting stops while it is held. Software then writes the counters and drops the request. A tick flag, which is also the interrupt level, is raised on every seconds increment or on every minute increment. A control bit chooses which.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the counters read as follows: seconds 00, minutes 00, hours 00, day-of-week 0, date 01, month 01, year 00. The control register reads 00 and irq is 0.
- R2: Counters are read at addresses 0 (seconds), 1 (minutes), 2 (hours), 3 (day-of-week), 4 (date), 5 (month) and 6 (year). Each is two BCD digits, upper digit in bits 7:4. Seconds and minutes count 00..59 and hours count 00..23. Each wraps to 00 and carries into the next counter.
- R3: Date wraps to 01 after the last day of its month. Months 01, 03, 05, 07, 08, 10 and 12 have 31 days, and months 04, 06, 09 and 11 have 30. The month wraps from 12 to 01 and carries into the year, and the year wraps from 99 to 00.
- R4: February has 29 days when the year value is divisible by 4, and 28 days otherwise.
- R5: Day-of-week counts 0..6 (0 is Monday) and advances by one on every date change, wrapping from 6 to 0.
- R6: One second is 2^PRESC_BITS cycles with tick_en high. Cycles with tick_en low do not advance the time.
- R7: The control register is at address 7. A write sets bit 0 = set request, bit 1 = seconds-tick select, and bit 2 = 1 clears the flag. A read returns bit 0 = set acknowledge, bit 1 = tick select, bit 2 = flag, bit 3 = set request. The acknowledge rises within 2^(PRESC_BITS-1) tick enables of the request and falls after the request is cleared.
- R8: While the acknowledge is high, counting is frozen and writes to addresses 0..6 load the counters. Writes to those addresses while the acknowledge is low leave the counters unchanged.
- R9: With tick select 1 the flag is set on every seconds increment. With tick select 0 it is set only on minute increments.
- R10: The flag stays set until software clears it, and a set in the same cycle wins over a clear. irq always equals the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low clock reset |
| tick_en | input | 1 | One-cycle enable at the 32.768 kHz rate |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data for addr (combinational) |
| irq | output | 1 | Tick interrupt level (the sticky flag) |

## Verification
A corrupted counter or a broken carry shows up in the register reads at the very next seconds increment. A date, month or year fault, however, appears only on the day a rollover occurs, so the bench loads 23:59:59 on the last day of every month across leap and non-leap years. A wrong prescaler or freeze state shows up as an increment interval other than 2^PRESC_BITS cycles, or as a counter that moves while the acknowledge is high. A wrong flag state is visible on irq within one second.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
   localparam int NUM_FIELDS = 7;

   // increments a packed two-digit BCD value
   function automatic logic [7:0] bcd_inc(input logic [7:0] b);
      if (b[3:0] >= 4'd9) bcd_inc = {b[7:4] + 4'd1, 4'd0};
      else                bcd_inc = {b[7:4], b[3:0] + 4'd1};
   endfunction

   // value mod 4 of a BCD year: (10*tens + units) mod 4 = (2*tens + units) mod 4
   function automatic logic is_leap(input logic [7:0] yr);
      logic [1:0] m;
      m = {yr[4], 1'b0} + yr[1:0];
      is_leap = (m == 2'd0);
   endfunction

   // last day of the month, in BCD
   function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
      case (mon)
         8'h02:                      month_len = is_leap(yr) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: month_len = 8'h30;
         default:                    month_len = 8'h31;
      endcase
   endfunction
endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
   parameter int PRESC_BITS = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic freeze,
   output logic sec_pulse,
   output logic half_mark
);
   localparam int HALF_BITS = PRESC_BITS - 1;

   if (PRESC_BITS < 2) begin : g_bad_width
      $error("rtc_prescaler: PRESC_BITS must be at least 2");
   end

   logic [PRESC_BITS-1:0] count;

   always_ff @(posedge clk) begin
      if (!rst_n)                count <= '0;
      else if (tick_en && !freeze) count <= count + 1'b1;
   end

   assign sec_pulse = tick_en && !freeze && (&count);
   assign half_mark = tick_en && (&count[HALF_BITS-1:0]);

   a_r8_frozen_count: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |=> $stable(count));
   a_r6_wrap_after_second: assert property (@(posedge clk) disable iff (!rst_n)
      sec_pulse |=> (count == '0));
endmodule

// File: rtl/rtc_bcd_field.sv
`timescale 1ns/1ps
module rtc_bcd_field
   import rtc_pkg::*;
#(
   parameter logic [7:0] RST_VAL = 8'h00,
   parameter logic [7:0] LOW_VAL = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       inc,
   input  logic       wr,
   input  logic [7:0] wdata,
   input  logic [7:0] max_val,
   output logic [7:0] val,
   output logic       carry
);
   logic at_top;
   assign at_top = (val >= max_val);

   always_ff @(posedge clk) begin
      if (!rst_n)   val <= RST_VAL;
      else if (wr)  val <= wdata;
      else if (inc) val <= at_top ? LOW_VAL : bcd_inc(val);
   end

   assign carry = inc && at_top;

   a_r2_wrap_to_low: assert property (@(posedge clk) disable iff (!rst_n)
      inc && !wr && (val >= max_val) |=> (val == LOW_VAL));
   a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !inc && !wr |=> $stable(val));
endmodule

// File: rtl/rtc_ctrl.sv
`timescale 1ns/1ps
module rtc_ctrl (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctrl_wr,
   input  logic [2:0] ctrl_data,
   input  logic       half_mark,
   input  logic       sec_inc,
   input  logic       min_inc,
   output logic       set_req,
   output logic       set_ack,
   output logic       sec_sel,
   output logic       flag
);
   logic tick_hit, flag_clr;
   assign tick_hit = sec_sel ? sec_inc : min_inc;
   assign flag_clr = ctrl_wr && ctrl_data[2];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         set_req <= 1'b0;
         sec_sel <= 1'b0;
         set_ack <= 1'b0;
         flag    <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            set_req <= ctrl_data[0];
            sec_sel <= ctrl_data[1];
         end
         set_ack <= set_req && (set_ack || half_mark);
         if (tick_hit)      flag <= 1'b1;
         else if (flag_clr) flag <= 1'b0;
      end
   end

   a_r7_ack_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      !set_req |=> !set_ack);
   a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      flag && !flag_clr |=> flag);
   a_r9_minute_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !sec_sel && min_inc |=> flag);
   a_r9_second_tick: assert property (@(posedge clk) disable iff (!rst_n)
      sec_sel && sec_inc |=> flag);
endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
   import rtc_pkg::*;
#(
   parameter int PRESC_BITS = 15,
   parameter int ADDR_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [7:0]        wr_data,
   output logic [7:0]        rd_data,
   output logic              irq
);
   localparam int NF = NUM_FIELDS;
   localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NF);

   if (ADDR_W < 3) begin : g_bad_addr
      $error("rtc_calendar: ADDR_W must cover eight registers");
   end

   logic sec_pulse, half_mark, set_req, set_ack, sec_sel, flag, ctrl_wr;
   logic c_sec, c_min, c_hour, c_dow, c_date, c_mon, c_year;
   logic [NF-1:0] fwr;
   logic [7:0] fval [NF];
   logic [7:0] dow_wdata, date_max;

   for (genvar i = 0; i < NF; i++) begin : g_wr
      assign fwr[i] = wr_en && set_ack && (addr == ADDR_W'(i));
   end

   assign ctrl_wr   = wr_en && (addr == CTRL_ADDR);
   assign dow_wdata = {5'b0, wr_data[2:0]};
   assign date_max  = month_len(fval[5], fval[6]);

   rtc_prescaler #(.PRESC_BITS(PRESC_BITS)) u_presc (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .freeze(set_ack),
      .sec_pulse(sec_pulse), .half_mark(half_mark));

   rtc_bcd_field #(.RST_VAL(8'h00), .LOW_VAL(8'h00)) u_sec (
      .clk(clk), .rst_n(rst_n), .inc(sec_pulse), .wr(fwr[0]), .wdata(wr_data),
      .max_val(8'h59), .val(fval[0]), .carry(c_sec));
   rtc_bcd_field #(.RST_VAL(8'h00), .LOW_VAL(8'h00)) u_min (
      .clk(clk), .rst_n(rst_n), .inc(c_sec), .wr(fwr[1]), .wdata(wr_data),
      .max_val(8'h59), .val(fval[1]), .carry(c_min));
   rtc_bcd_field #(.RST_VAL(8'h00), .LOW_VAL(8'h00)) u_hour (
      .clk(clk), .rst_n(rst_n), .inc(c_min), .wr(fwr[2]), .wdata(wr_data),
      .max_val(8'h23), .val(fval[2]), .carry(c_hour));
   rtc_bcd_field #(.RST_VAL(8'h00), .LOW_VAL(8'h00)) u_dow (
      .clk(clk), .rst_n(rst_n), .inc(c_hour), .wr(fwr[3]), .wdata(dow_wdata),
      .max_val(8'h06), .val(fval[3]), .carry(c_dow));
   rtc_bcd_field #(.RST_VAL(8'h01), .LOW_VAL(8'h01)) u_date (
      .clk(clk), .rst_n(rst_n), .inc(c_hour), .wr(fwr[4]), .wdata(wr_data),
      .max_val(date_max), .val(fval[4]), .carry(c_date));
   rtc_bcd_field #(.RST_VAL(8'h01), .LOW_VAL(8'h01)) u_mon (
      .clk(clk), .rst_n(rst_n), .inc(c_date), .wr(fwr[5]), .wdata(wr_data),
      .max_val(8'h12), .val(fval[5]), .carry(c_mon));
   rtc_bcd_field #(.RST_VAL(8'h00), .LOW_VAL(8'h00)) u_year (
      .clk(clk), .rst_n(rst_n), .inc(c_mon), .wr(fwr[6]), .wdata(wr_data),
      .max_val(8'h99), .val(fval[6]), .carry(c_year));

   rtc_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_data(wr_data[2:0]),
      .half_mark(half_mark), .sec_inc(sec_pulse), .min_inc(c_sec),
      .set_req(set_req), .set_ack(set_ack), .sec_sel(sec_sel), .flag(flag));

   always_comb begin
      rd_data = 8'h00;
      for (int i = 0; i < NF; i++) begin
         if (addr == ADDR_W'(i)) rd_data = fval[i];
      end
      if (addr == CTRL_ADDR) rd_data = {4'b0, set_req, flag, sec_sel, set_ack};
   end

   assign irq = flag;

   // the year carry has no consumer: the calendar ends at 99
   logic unused_year_carry;
   assign unused_year_carry = c_year ^ c_dow;

   a_r8_no_count_while_set: assert property (@(posedge clk) disable iff (!rst_n)
      set_ack |-> !sec_pulse);
   a_r8_frozen_seconds: assert property (@(posedge clk) disable iff (!rst_n)
      set_ack && !fwr[0] |=> $stable(fval[0]));
   a_r5_dow_with_date: assert property (@(posedge clk) disable iff (!rst_n)
      c_hour && !set_ack |=> (fval[3] != $past(fval[3])) && (fval[4] != $past(fval[4])));
endmodule

// File: tb/tb_rtc_calendar.sv
`timescale 1ns/1ps
module tb_rtc_calendar;
   localparam int PB = 3;
   localparam int SEC_CYC = 1 << PB;
   localparam int HALF = 1 << (PB - 1);

   logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, wr_en = 1'b0, irq;
   logic [2:0] addr = 3'd0;
   logic [7:0] wr_data = 8'h00, rd_data, rv;

   int nchk = 0, nfail = 0, cyc = 0, tlast = 0;
   int es, em, eh, edw, ed, emo, ey;
   logic cur_sel, eflag, first;

   rtc_calendar #(.PRESC_BITS(PB), .ADDR_W(3)) dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   endtask

   always @(posedge clk) begin
      if (cyc == 150000) begin
         nfail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         summary();
      end
   end

   function automatic logic [7:0] to_bcd(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int dim(input int m, input int y);
      if (m == 2) return (y % 4 == 0) ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic rd(input int a, output logic [7:0] v);
      addr = 3'(a);
      #0.1;
      v = rd_data;
   endtask

   task automatic wr(input int a, input logic [7:0] d);
      addr = 3'(a);
      wr_data = d;
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic advance();
      es++;
      if (es == 60) begin
         es = 0; em++;
         if (em == 60) begin
            em = 0; eh++;
            if (eh == 24) begin
               eh = 0;
               edw = (edw + 1) % 7;
               ed++;
               if (ed > dim(emo, ey)) begin
                  ed = 1; emo++;
                  if (emo == 13) begin
                     emo = 1; ey = (ey + 1) % 100;
                  end
               end
            end
         end
      end
   endtask

   task automatic cmp_all();
      logic [7:0] v;
      rd(0, v); chk("R2 seconds", v, to_bcd(es));
      rd(1, v); chk("R2 minutes", v, to_bcd(em));
      rd(2, v); chk("R2 hours", v, to_bcd(eh));
      rd(3, v); chk("R5 day of week", v, 8'(edw));
      rd(4, v); chk("R3 date", v, to_bcd(ed));
      rd(5, v); chk("R3 month", v, to_bcd(emo));
      rd(6, v); chk("R3 year", v, to_bcd(ey));
   endtask

   task automatic load(input int s, input int m, input int h, input int dw, input int d,
                       input int mo, input int y, input logic sel, input logic hold);
      int n;
      logic [7:0] v;
      wr(7, {5'b0, 1'b1, sel, 1'b1});
      n = 0;
      do begin
         @(negedge clk);
         n++;
         rd(7, v);
      end while (!v[0] && n < 40);
      chk("R7 acknowledge raised", {7'b0, v[0]}, 8'h01);
      chk("R7 acknowledge within half period", 8'(n <= HALF), 8'h01);
      wr(0, to_bcd(s)); wr(1, to_bcd(m)); wr(2, to_bcd(h)); wr(3, 8'(dw));
      wr(4, to_bcd(d)); wr(5, to_bcd(mo)); wr(6, to_bcd(y));
      if (hold) begin
         repeat (5 * SEC_CYC) @(negedge clk);
         rd(0, v); chk("R8 seconds frozen while acknowledged", v, to_bcd(s));
         rd(4, v); chk("R8 date loaded while acknowledged", v, to_bcd(d));
      end
      wr(7, {5'b0, 1'b1, sel, 1'b0});
      @(negedge clk);
      @(negedge clk);
      rd(7, v); chk("R7 acknowledge released", {7'b0, v[0]}, 8'h00);
      es = s; em = m; eh = h; edw = dw; ed = d; emo = mo; ey = y;
      cur_sel = sel; eflag = 1'b0; first = 1'b1;
   endtask

   task automatic run_secs(input int n, input logic clr);
      logic [7:0] v, old;
      int k;
      for (int i = 0; i < n; i++) begin
         old = to_bcd(es);
         k = 0;
         do begin
            @(negedge clk);
            k++;
            rd(0, v);
         end while (v == old && k < 4 * SEC_CYC);
         if (k >= 4 * SEC_CYC) chk("R6 seconds advance", v, to_bcd((es + 1) % 60));
         advance();
         cmp_all();
         if (!first) chk("R6 second interval", 8'(cyc - tlast), 8'(SEC_CYC));
         tlast = cyc;
         first = 1'b0;
         if (cur_sel || es == 0) eflag = 1'b1;
         rd(7, v);
         chk("R9 tick flag", {7'b0, v[2]}, {7'b0, eflag});
         chk("R10 irq follows flag", {7'b0, irq}, {7'b0, eflag});
         if (clr && eflag) begin
            wr(7, {5'b0, 1'b1, cur_sel, 1'b0});
            eflag = 1'b0;
         end
      end
   endtask

   initial begin
      int yrs [7] = '{0, 1, 2, 3, 4, 96, 99};
      int k;
      logic [7:0] v;
      logic [7:0] rst_exp [7] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 7; a++) begin
         rd(a, v); chk("R1 reset value", v, rst_exp[a]);
      end
      rd(7, v); chk("R1 control reset", v, 8'h00);
      chk("R1 irq reset", {7'b0, irq}, 8'h00);

      // R6 no time without tick_en, then exactly one period for the first second
      repeat (20) @(negedge clk);
      rd(0, v); chk("R6 no advance without tick_en", v, 8'h00);
      tick_en = 1'b1;
      k = 0;
      do begin
         @(negedge clk);
         k++;
         rd(0, v);
      end while (v == 8'h00 && k < 40);
      chk("R6 first second length", 8'(k), 8'(SEC_CYC));
      chk("R6 first second value", v, 8'h01);

      // seconds tick across a minute rollover, with a frozen load (R8, R9)
      load(56, 34, 12, 2, 15, 6, 23, 1'b1, 1'b1);
      run_secs(70, 1'b1);

      // minute tick across an hour rollover
      load(50, 58, 22, 4, 9, 11, 7, 1'b0, 1'b0);
      run_secs(75, 1'b1);

      // R10 flag stays set without a clear
      load(57, 0, 10, 0, 3, 3, 50, 1'b0, 1'b0);
      run_secs(6, 1'b0);

      // R8 writes without acknowledge are ignored
      wr(0, 8'h42);
      rd(0, v); chk("R8 seconds write ignored", v, to_bcd(es));
      wr(6, 8'h55);
      rd(6, v); chk("R8 year write ignored", v, to_bcd(ey));
      run_secs(1, 1'b1);

      // R3 R4 R5 month-end sweep over leap and common years
      foreach (yrs[yi]) begin
         for (int m = 1; m <= 12; m++) begin
            load(59, 59, 23, (m + yrs[yi]) % 7, dim(m, yrs[yi]), m, yrs[yi], 1'b0, 1'b0);
            run_secs(1, 1'b1);
            if (m == 2) begin
               load(59, 59, 23, 6, 28, 2, yrs[yi], 1'b0, 1'b0);
               run_secs(1, 1'b1);
               rd(4, v);
               chk("R4 february day after 28", v, (yrs[yi] % 4 == 0) ? 8'h29 : 8'h01);
            end
         end
      end

      summary();
   end
endmodule